// File: doc/BRIEF.md
# Synthesizer Divider Serial Loader

This block receives a divider programming word over a three-wire serial link and updates the divider values of a frequency synthesizer from it. The link has a data line, a shift clock and a load strobe. The three lines come from a host that may run on another clock. Inside the block, each line passes through a two-stage synchronizer. The block then acts on the edges it finds in its own system clock domain.

Each rising edge of the shift clock pushes one data bit into a 32-bit chain. The first stage of the chain is a one-bit mode cell. Bits leave that cell and move on through the swallow field (7 bits), the main field (10 bits) and the reference field (14 bits).

A rising edge on the load strobe copies the fields into the held divider outputs. The mode cell holds the last bit sent, and it decides whether the reference divider is included in the update. A one-cycle strobe marks each update, and a flag tells whether the reference value was part of it. A run flag stays low after reset until the first update that includes the reference value. It tells the counters that all three of their values are valid.

Top module: `synth_prog_loader`

## Requirements
- R1: While reset is high and in the cycle after it, swallow_o, main_o and ref_o read 0, and upd_o, upd_ref_o and run_o read 0.
- R2: One bit is shifted per low-to-high transition of ser_clk_i, using the value on ser_data_i at that transition. A change of ser_data_i while ser_clk_i is high, or at its falling edge, has no effect.
- R3: A word is 32 bits, sent most significant bit first, in this order: the reference value (14 bits, MSB first), the main value (10 bits), the swallow value (7 bits), then the mode bit last.
- R4: On a load with mode bit 1, swallow_o, main_o and ref_o all take the shifted fields, and upd_ref_o is 1 together with upd_o.
- R5: On a load with mode bit 0, swallow_o and main_o take the shifted fields, ref_o keeps its previous value, and upd_ref_o stays 0 during the upd_o pulse.
- R6: upd_o is high for exactly one system clock per rising edge of ser_le_i, however long ser_le_i stays high. The held outputs change only in a cycle where upd_o is high.
- R7: run_o stays 0 until the first load with mode bit 1. It then stays 1 until reset.
- R8: If ser_le_i rises between two system clock edges, the held outputs and upd_o change at the third rising clk edge after that.
- R9: When more than 32 bits are shifted before a load, only the last 32 bits are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data_i | input | 1 | Serial data, asynchronous to clk |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous to clk |
| ser_le_i | input | 1 | Load strobe, acts on its rising edge |
| swallow_o | output | 7 | Held swallow divider value |
| main_o | output | 10 | Held main divider value |
| ref_o | output | 14 | Held reference divider value |
| upd_o | output | 1 | One-cycle pulse marking an update |
| upd_ref_o | output | 1 | High with upd_o when the reference value was updated |
| run_o | output | 1 | Counters may run; set by the first full load |

## Verification
The first word loaded has mode bit 0. This shows that the reference value and the run flag do not move until a full load has happened. Full and partial loads then alternate. The partial loads carry a distinctive reference field that must be ignored. A word preceded by eight junk bits checks that only the last 32 bits are kept. A word whose data line is inverted while the shift clock is high separates rising-edge sampling from falling-edge sampling. A load strobe held high for many cycles, together with a cycle-exact latency probe, pins down the strobe width and the synchronizer delay.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
    parameter int SWL_W = 7;
    parameter int MAIN_W = 10;
    parameter int REF_W = 14;
    localparam int WORD_W = REF_W + MAIN_W + SWL_W + 1;

    // Field layout of the shift chain; the last bit received sits in mode.
    typedef struct packed {
        logic [REF_W-1:0]  ref_div;
        logic [MAIN_W-1:0] main_div;
        logic [SWL_W-1:0]  swl_div;
        logic              mode;
    } prog_word_t;

    typedef struct packed {
        logic [REF_W-1:0]  ref_div;
        logic [MAIN_W-1:0] main_div;
        logic [SWL_W-1:0]  swl_div;
    } div_set_t;

    function automatic div_set_t word_to_divs(input prog_word_t w);
        div_set_t d;
        d.ref_div  = w.ref_div;
        d.main_div = w.main_div;
        d.swl_div  = w.swl_div;
        return d;
    endfunction
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
    parameter int W = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[g] <= '0;
                end else begin
                    if (g == 0) stage_q[g] <= async_i;
                    else        stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= '0;
        else     last_q <= stage_q[STAGES-1];
    end

    assign level_o = stage_q[STAGES-1];
    assign rise_o  = stage_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sp_chain.sv
module sp_chain
    import synth_prog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       shift_i,
    input  logic       bit_i,
    output prog_word_t word_o
);
    logic [WORD_W-1:0] chain_q;

    // New bits enter the mode cell at bit 0 and move toward the reference field.
    always_ff @(posedge clk) begin
        if (rst)          chain_q <= '0;
        else if (shift_i) chain_q <= {chain_q[WORD_W-2:0], bit_i};
    end

    assign word_o = prog_word_t'(chain_q);
endmodule

// File: rtl/sp_hold.sv
module sp_hold
    import synth_prog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  prog_word_t word_i,
    output div_set_t   divs_o,
    output logic       upd_o,
    output logic       upd_ref_o,
    output logic       run_o
);
    div_set_t next_divs;
    div_set_t divs_q;
    logic     upd_q, upd_ref_q, run_q;

    always_comb begin
        next_divs = word_to_divs(word_i);
        if (!word_i.mode) next_divs.ref_div = divs_q.ref_div;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            divs_q    <= '0;
            upd_q     <= 1'b0;
            upd_ref_q <= 1'b0;
            run_q     <= 1'b0;
        end else begin
            upd_q     <= load_i;
            upd_ref_q <= load_i & word_i.mode;
            if (load_i) begin
                divs_q <= next_divs;
                if (word_i.mode) run_q <= 1'b1;
            end
        end
    end

    assign divs_o    = divs_q;
    assign upd_o     = upd_q;
    assign upd_ref_o = upd_ref_q;
    assign run_o     = run_q;
endmodule

// File: rtl/synth_prog_loader.sv
module synth_prog_loader
    import synth_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_data_i,
    input  logic              ser_clk_i,
    input  logic              ser_le_i,
    output logic [SWL_W-1:0]  swallow_o,
    output logic [MAIN_W-1:0] main_o,
    output logic [REF_W-1:0]  ref_o,
    output logic              upd_o,
    output logic              upd_ref_o,
    output logic              run_o
);
    localparam int IDX_DATA = 0;
    localparam int IDX_SCLK = 1;
    localparam int IDX_LE   = 2;

    logic [2:0] lvl, rise;
    prog_word_t word;
    div_set_t   divs;

    sp_sync #(.W(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ser_le_i, ser_clk_i, ser_data_i}),
        .level_o (lvl),
        .rise_o  (rise)
    );

    sp_chain u_chain (
        .clk     (clk),
        .rst     (rst),
        .shift_i (rise[IDX_SCLK]),
        .bit_i   (lvl[IDX_DATA]),
        .word_o  (word)
    );

    sp_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .load_i    (rise[IDX_LE]),
        .word_i    (word),
        .divs_o    (divs),
        .upd_o     (upd_o),
        .upd_ref_o (upd_ref_o),
        .run_o     (run_o)
    );

    assign swallow_o = divs.swl_div;
    assign main_o    = divs.main_div;
    assign ref_o     = divs.ref_div;
endmodule

// File: rtl/synth_prog_checker.sv
module synth_prog_checker
    import synth_prog_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [SWL_W-1:0]  swallow_o,
    input logic [MAIN_W-1:0] main_o,
    input logic [REF_W-1:0]  ref_o,
    input logic              upd_o,
    input logic              upd_ref_o,
    input logic              run_o
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (swallow_o == '0 && main_o == '0 && ref_o == '0 && !upd_o && !upd_ref_o && !run_o));

    p_ref_flag_r4: assert property (@(posedge clk) disable iff (rst)
        upd_ref_o |-> upd_o);

    p_ref_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_o && !upd_ref_o) |-> $stable(ref_o));

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        upd_o |=> !upd_o);

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !upd_o |-> ($stable(swallow_o) && $stable(main_o) && $stable(ref_o)));

    p_run_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        run_o |=> run_o);

    p_run_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(run_o) |-> upd_ref_o);
endmodule

bind synth_prog_loader synth_prog_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .swallow_o (swallow_o),
    .main_o    (main_o),
    .ref_o     (ref_o),
    .upd_o     (upd_o),
    .upd_ref_o (upd_ref_o),
    .run_o     (run_o)
);

// File: tb/sim_synth_prog_loader.sv
`timescale 1ns/1ps
module sim_synth_prog_loader;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sdat = 1'b0, sclk = 1'b0, sle = 1'b0;
    logic [6:0]  swl;
    logic [9:0]  mdiv;
    logic [13:0] rdiv;
    logic upd, upd_ref, run;
    int tests = 0, fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    synth_prog_loader u0 (
        .clk(clk), .rst(rst), .ser_data_i(sdat), .ser_clk_i(sclk), .ser_le_i(sle),
        .swallow_o(swl), .main_o(mdiv), .ref_o(rdiv),
        .upd_o(upd), .upd_ref_o(upd_ref), .run_o(run)
    );

    // Behavioural reference: the block acts on what each input was two edges ago.
    bit hd[$], hc[$], hl[$];
    bit [31:0] m_word;
    int m_a, m_n, m_r;
    bit m_upd, m_uref, m_run;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            hd = {0, 0, 0}; hc = {0, 0, 0}; hl = {0, 0, 0};
            m_word = 0; m_a = 0; m_n = 0; m_r = 0;
            m_upd = 0; m_uref = 0; m_run = 0;
        end else begin
            // hX[1] = value two edges ago, hX[2] = three edges ago
            m_upd = 0; m_uref = 0;
            if (hl[1] && !hl[2]) begin
                m_upd = 1;
                m_a = int'(m_word[7:1]);
                m_n = int'(m_word[17:8]);
                if (m_word[0]) begin
                    m_r = int'(m_word[31:18]);
                    m_uref = 1; m_run = 1;
                end
            end
            if (hc[1] && !hc[2]) m_word = {m_word[30:0], hd[1]};
        end
        hd.push_front(sdat); void'(hd.pop_back());
        hc.push_front(sclk); void'(hc.pop_back());
        hl.push_front(sle);  void'(hl.pop_back());
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the reference model (R8 timing, R6 pulse shape).
    always @(negedge clk) begin
        if (!rst) begin
            chk("R8 model swallow", int'(swl), m_a);
            chk("R8 model main", int'(mdiv), m_n);
            chk("R8 model ref", int'(rdiv), m_r);
            chk("R6 model upd", int'(upd), int'(m_upd));
            chk("R6 model upd_ref", int'(upd_ref), int'(m_uref));
            chk("R7 model run", int'(run), int'(m_run));
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b, input bit glitch);
        sdat = b; wait_cyc(3);
        sclk = 1'b1; wait_cyc(3);
        if (glitch) sdat = ~b;
        wait_cyc(3);
        sclk = 1'b0; wait_cyc(3);
        sdat = b;
    endtask

    task automatic send_word(input bit mode, input int a, input int n, input int r, input bit glitch);
        bit [31:0] w;
        w = {r[13:0], n[9:0], a[6:0], mode};
        for (int i = 31; i >= 0; i--) send_bit(w[i], glitch);
    endtask

    task automatic latch(input int hold);
        sle = 1'b1; wait_cyc(hold);
        sle = 1'b0; wait_cyc(4);
    endtask

    task automatic expect_divs(input string req, input int a, input int n, input int r);
        chk({req, " swallow"}, int'(swl), a);
        chk({req, " main"}, int'(mdiv), n);
        chk({req, " ref"}, int'(rdiv), r);
    endtask

    int pulses;
    initial begin
        wait_cyc(4);
        // R1: reset state
        chk("R1 swallow", int'(swl), 0);
        chk("R1 main", int'(mdiv), 0);
        chk("R1 ref", int'(rdiv), 0);
        chk("R1 upd", int'(upd), 0);
        chk("R1 run", int'(run), 0);
        rst = 1'b0;
        wait_cyc(2);
        chk("R1 after release run", int'(run), 0);

        // R5/R7: first load with mode 0 leaves ref and run untouched
        send_word(1'b0, 21, 333, 12345, 1'b0);
        latch(4);
        expect_divs("R5 partial first", 21, 333, 0);
        chk("R7 run stays low", int'(run), 0);

        // R4/R3/R7: full load
        send_word(1'b1, 55, 508, 1400, 1'b0);
        latch(4);
        expect_divs("R4 full load R3 order", 55, 508, 1400);
        chk("R7 run set", int'(run), 1);

        // R5: partial load ignores a distinctive ref field
        send_word(1'b0, 3, 100, 16383, 1'b0);
        latch(4);
        expect_divs("R5 partial", 3, 100, 1400);

        // R9: eight junk bits before a full word
        for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0);
        send_word(1'b1, 127, 1, 2, 1'b0);
        latch(4);
        expect_divs("R9 last 32 bits", 127, 1, 2);

        // R2: data inverted while sclk high must not matter
        send_word(1'b1, 42, 682, 10922, 1'b1);
        latch(4);
        expect_divs("R2 rising edge sampling", 42, 682, 10922);

        // R6: long latch pulse gives one upd cycle
        send_word(1'b0, 9, 9, 9, 1'b0);
        pulses = 0;
        sle = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (upd) pulses++;
        end
        sle = 1'b0; wait_cyc(4);
        chk("R6 one pulse", pulses, 1);
        expect_divs("R6 partial value", 9, 9, 10922);

        // R8: exact latency, ready a full word then raise le just after a negedge
        send_word(1'b1, 1, 2, 3, 1'b0);
        sle = 1'b1;
        @(negedge clk); chk("R8 edge1 no upd", int'(upd), 0);
        @(negedge clk); chk("R8 edge2 no upd", int'(upd), 0);
        chk("R8 edge2 old ref", int'(rdiv), 10922);
        @(negedge clk); chk("R8 edge3 upd", int'(upd), 1);
        chk("R8 edge3 upd_ref", int'(upd_ref), 1);
        chk("R8 edge3 ref", int'(rdiv), 3);
        sle = 1'b0; wait_cyc(4);

        // R1/R7: reset clears run
        rst = 1'b1; wait_cyc(2);
        chk("R1 rerun reset ref", int'(rdiv), 0);
        chk("R7 run cleared", int'(run), 0);
        rst = 1'b0; wait_cyc(2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1500000;
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule